// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synchronous single-port SRAM. Reads are pipelined through a registered output, and writes take their data one cycle late. Every command is taken on the rising clock edge. A command loads a new address when the load strobe is low. It continues a burst from the previously loaded address when the strobe is high.

Write data and byte lanes arrive one edge after the write command. They wait in a one-entry write buffer, and that buffer is committed to the storage array only when the next write's data comes in. Reads compare their address against this buffer and merge in any pending bytes. A read therefore always returns the latest written value.

Three chip selects gate the block. The first is active low. The active level of the second and third is set by two strap inputs. An echo-clock enable follows only the second and third selects. After read data, the output enable stays on through one idle cycle and turns off on the second consecutive idle cycle.

Top module: `lwsram`

## Requirements
- R1: A cycle is selected only when `e1_n` is 0, `e2` equals `e2_pol` and `e3` equals `e3_pol`. The strap value 1 makes a select active high, and 0 makes it active low. An unselected cycle performs no read and no write.
- R2: A selected cycle with `adv`=0 and `we_n`=1 is a read of `addr`. The word appears on `dout` with `dout_en`=1 after the second rising edge, counting the capturing edge as the first.
- R3: A selected cycle with `adv`=0 and `we_n`=0 is a write of `addr`. Its `din` and `bw_n` are taken on the following rising edge. The values present on the command edge itself are ignored.
- R4: `bw_n[i]`=0 writes byte i, which is bits i*9+8 down to i*9. Bytes whose `bw_n` bit is 1 keep their old contents.
- R5: A read returns the newest data of its address. This holds when the read is issued on the edge where that address's write data arrives, and it holds with partial byte writes merged over older contents.
- R6: A selected cycle with `adv`=1 repeats the kind of the last loaded command (read or write). Its address is the previous command address with the two low bits incremented modulo 4 and the upper bits unchanged.
- R7: A selected cycle with `adv`=1 before any load since reset is an idle cycle.
- R8: After a read cycle, `dout_en` is 1. After a write cycle, it is 0. After an idle cycle, it keeps its value unless the cycle before was also idle, in which case it becomes 0. `dout` holds the last read word while no new read arrives.
- R9: After each rising edge, `echo_en` is 1 exactly when `e2` and `e3` were both at their active levels on that edge. `e1_n` has no effect on it.
- R10: While `rst_n` is 0, `dout`, `dout_en` and `echo_en` are 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address for load cycles |
| adv | input | 1 | 0 = load new address, 1 = continue burst |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | NBYTE | Byte write enables, active low, taken one edge late |
| e1_n | input | 1 | Chip select, active low |
| e2 | input | 1 | Chip select, polarity from e2_pol |
| e3 | input | 1 | Chip select, polarity from e3_pol |
| e2_pol | input | 1 | Strap: active level of e2 |
| e3_pol | input | 1 | Strap: active level of e3 |
| din | input | NBYTE*BYTE_W | Write data, taken one edge after the write command |
| dout | output | NBYTE*BYTE_W | Registered read data |
| dout_en | output | 1 | Output drive enable |
| echo_en | output | 1 | Echo-clock enable |

## Verification
The bench targets several corner cases.

- It issues a read on the very edge where the write data for that address lands. A design without forwarding returns the stale array word.
- It rewrites a word with a partial byte mask while the old full word is still being committed. A wrong merge either loses the unwritten bytes or returns the entire buffered word.
- It runs bursts that cross the modulo-4 boundary of the low address bits. A wrong counter carries into the upper bits and reads the wrong words.
- It checks the output enable through one and two idle cycles and across a write. An off-by-one deselect releases the bus one cycle early or late.
- It puts burst-continue commands before any load, deselects through each select in turn, and flips the strap polarities. These catch echo enables that follow the wrong select and selects decoded at a fixed polarity.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              we_n_i,
  input  logic              e1_n_i,
  input  logic              e2_i,
  input  logic              e3_i,
  input  logic              e2_pol_i,
  input  logic              e3_pol_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              echo_sel_o
);
  // Burst step: low two bits wrap, upper bits stay
  function automatic logic [ADDR_W-1:0] burst_step(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r      = a;
    r[1:0] = a[1:0] + 2'd1;
    return r;
  endfunction

  logic              e2_ok, e3_ok, sel;
  logic              load_go, cont_go;
  logic              loaded_q, last_wr_q;
  logic [ADDR_W-1:0] base_q;

  assign e2_ok      = (e2_i == e2_pol_i);
  assign e3_ok      = (e3_i == e3_pol_i);
  assign sel        = ~e1_n_i & e2_ok & e3_ok;
  assign echo_sel_o = e2_ok & e3_ok;
  assign load_go    = sel & ~adv_i;
  assign cont_go    = sel & adv_i & loaded_q;

  always_comb begin
    op_o      = OP_IDLE;
    op_addr_o = base_q;
    if (load_go) begin
      op_o      = we_n_i ? OP_READ : OP_WRITE;
      op_addr_o = addr_i;
    end else if (cont_go) begin
      op_o      = last_wr_q ? OP_WRITE : OP_READ;
      op_addr_o = burst_step(base_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q  <= 1'b0;
      last_wr_q <= 1'b0;
      base_q    <= '0;
    end else if (load_go) begin
      loaded_q  <= 1'b1;
      last_wr_q <= ~we_n_i;
      base_q    <= addr_i;
    end else if (cont_go) begin
      base_q    <= burst_step(base_q);
    end
  end
endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf #(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_is_wr_i,
  input  logic [ADDR_W-1:0]        op_addr_i,
  input  logic [NBYTE*BYTE_W-1:0]  din_i,
  input  logic [NBYTE-1:0]         bw_n_i,
  output logic                     commit_en_o,
  output logic [ADDR_W-1:0]        wb_addr_o,
  output logic [NBYTE*BYTE_W-1:0]  wb_data_o,
  output logic [NBYTE-1:0]         wb_mask_o,
  output logic                     wb_valid_o
);
  localparam int DATA_W = NBYTE * BYTE_W;

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              wb_valid_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;
  logic [NBYTE-1:0]  wb_mask_q;

  // Old buffer content moves to the array when new write data arrives
  assign commit_en_o = pend_q & wb_valid_q;
  assign wb_addr_o   = wb_addr_q;
  assign wb_data_o   = wb_data_q;
  assign wb_mask_o   = wb_mask_q;
  assign wb_valid_o  = wb_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      wb_valid_q  <= 1'b0;
      wb_addr_q   <= '0;
      wb_data_q   <= '0;
      wb_mask_q   <= '0;
    end else begin
      pend_q      <= op_is_wr_i;
      pend_addr_q <= op_addr_i;
      if (pend_q) begin
        wb_valid_q <= 1'b1;
        wb_addr_q  <= pend_addr_q;
        wb_data_q  <= din_i;
        wb_mask_q  <= ~bw_n_i;
      end
    end
  end
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [NBYTE*BYTE_W-1:0] wdata_i,
  input  logic [NBYTE-1:0]        wmask_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [NBYTE*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTE; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && wmask_i[g]) mem[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTE  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [NBYTE-1:0]        bw_n,
  input  logic                    e1_n,
  input  logic                    e2,
  input  logic                    e3,
  input  logic                    e2_pol,
  input  logic                    e3_pol,
  input  logic [NBYTE*BYTE_W-1:0] din,
  output logic [NBYTE*BYTE_W-1:0] dout,
  output logic                    dout_en,
  output logic                    echo_en
);
  localparam int DATA_W = NBYTE * BYTE_W;

  // Lay buffered bytes over the array word
  function automatic logic [DATA_W-1:0] overlay(input logic [DATA_W-1:0] base,
                                                input logic [DATA_W-1:0] upd,
                                                input logic [NBYTE-1:0]  take);
    logic [DATA_W-1:0] r;
    r = base;
    for (int i = 0; i < NBYTE; i++)
      if (take[i]) r[i*BYTE_W +: BYTE_W] = upd[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  op_e               op_w;
  logic [ADDR_W-1:0] op_addr_w;
  logic              echo_sel_w;
  logic              commit_w;
  logic              wb_valid_w;
  logic [ADDR_W-1:0] wb_addr_w;
  logic [DATA_W-1:0] wb_data_w;
  logic [NBYTE-1:0]  wb_mask_w;
  logic [DATA_W-1:0] arr_rdata_w;

  op_e               s1_op_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic              idle_seen_q;
  logic              fwd_hit_w;
  logic [DATA_W-1:0] rd_word_w;

  lwsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .adv_i(adv), .we_n_i(we_n),
    .e1_n_i(e1_n), .e2_i(e2), .e3_i(e3), .e2_pol_i(e2_pol), .e3_pol_i(e3_pol),
    .op_o(op_w), .op_addr_o(op_addr_w), .echo_sel_o(echo_sel_w)
  );

  lwsram_wbuf #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .op_is_wr_i(op_w == OP_WRITE), .op_addr_i(op_addr_w),
    .din_i(din), .bw_n_i(bw_n), .commit_en_o(commit_w), .wb_addr_o(wb_addr_w),
    .wb_data_o(wb_data_w), .wb_mask_o(wb_mask_w), .wb_valid_o(wb_valid_w)
  );

  lwsram_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .we_i(commit_w), .waddr_i(wb_addr_w), .wdata_i(wb_data_w),
    .wmask_i(wb_mask_w), .raddr_i(s1_addr_q), .rdata_o(arr_rdata_w)
  );

  assign fwd_hit_w = wb_valid_w && (wb_addr_w == s1_addr_q);
  assign rd_word_w = fwd_hit_w ? overlay(arr_rdata_w, wb_data_w, wb_mask_w) : arr_rdata_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q     <= OP_IDLE;
      s1_addr_q   <= '0;
      dout        <= '0;
      dout_en     <= 1'b0;
      echo_en     <= 1'b0;
      idle_seen_q <= 1'b0;
    end else begin
      s1_op_q   <= op_w;
      s1_addr_q <= op_addr_w;
      echo_en   <= echo_sel_w;
      case (s1_op_q)
        OP_READ: begin
          dout        <= rd_word_w;
          dout_en     <= 1'b1;
          idle_seen_q <= 1'b0;
        end
        OP_WRITE: begin
          dout_en     <= 1'b0;
          idle_seen_q <= 1'b0;
        end
        default: begin
          if (idle_seen_q) dout_en <= 1'b0;
          idle_seen_q <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input op_e               op_i,
  input logic [ADDR_W-1:0] op_addr_i,
  input logic              adv_i,
  input logic              e1_n_i,
  input logic              e2_i,
  input logic              e3_i,
  input logic              e2_pol_i,
  input logic              e3_pol_i,
  input logic              dout_en_i,
  input logic              echo_en_i
);
  op_e               op_d1, op_d2, op_d3;
  logic              e23_q, seen_load_q;
  logic [ADDR_W-1:0] last_a_q;
  logic              e23, sel_p;

  assign e23   = (e2_i == e2_pol_i) && (e3_i == e3_pol_i);
  assign sel_p = !e1_n_i && e23;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_d1 <= OP_IDLE; op_d2 <= OP_IDLE; op_d3 <= OP_IDLE;
      e23_q <= 1'b0; seen_load_q <= 1'b0; last_a_q <= '0;
    end else begin
      op_d1 <= op_i; op_d2 <= op_d1; op_d3 <= op_d2;
      e23_q <= e23;
      if (sel_p && !adv_i) seen_load_q <= 1'b1;
      if (op_i != OP_IDLE) last_a_q <= op_addr_i;
    end
  end

  p_desel_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_p |-> op_i == OP_IDLE);
  p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_d2 == OP_READ |-> dout_en_i);
  p_write_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_d2 == OP_WRITE |-> !dout_en_i);
  p_dual_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_d2 == OP_IDLE && op_d3 == OP_IDLE) |-> !dout_en_i);
  p_burst_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_p && adv_i && seen_load_q) |-> (op_i != OP_IDLE &&
      op_addr_i[1:0] == last_a_q[1:0] + 2'd1 &&
      op_addr_i[ADDR_W-1:2] == last_a_q[ADDR_W-1:2]));
  p_cont_unloaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_p && adv_i && !seen_load_q) |-> op_i == OP_IDLE);
  p_echo_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    echo_en_i == e23_q);
endmodule

bind lwsram lwsram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_w), .op_addr_i(op_addr_w), .adv_i(adv),
  .e1_n_i(e1_n), .e2_i(e2), .e3_i(e3), .e2_pol_i(e2_pol), .e3_pol_i(e3_pol),
  .dout_en_i(dout_en), .echo_en_i(echo_en)
);

// File: tb/lwsram_tb.sv
module lwsram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic adv = 1'b0, we_n = 1'b1, e1_n = 1'b1, e2 = 1'b1, e3 = 1'b1;
  logic e2_pol = 1'b1, e3_pol = 1'b1;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, echo_en;

  lwsram #(.ADDR_W(AW), .NBYTE(NB), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adv(adv), .we_n(we_n), .bw_n(bw_n),
    .e1_n(e1_n), .e2(e2), .e3(e3), .e2_pol(e2_pol), .e3_pol(e3_pol),
    .din(din), .dout(dout), .dout_en(dout_en), .echo_en(echo_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int            due;
    bit            is_echo;
    logic          en;
    logic [DW-1:0] dat;
    string         req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;

  // bench-side reference state
  logic [DW-1:0] mdl [1<<AW];
  bit            pend = 0, loaded = 0, last_wr = 0, idle_prev = 0;
  logic [AW-1:0] pend_a = '0, last_a = '0;
  logic          en_m = 1'b0;
  logic [DW-1:0] dat_m = '0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: pops scoreboard items when due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.is_echo) check(it.req, DW'(echo_en), DW'(it.en));
      else begin
        check(it.req, DW'(dout_en), DW'(it.en));
        if (it.en) check(it.req, dout, it.dat);
      end
    end
  end

  // driver: one command per cycle; d/bwn belong to the previous write
  task automatic step(input logic e1v, input logic e2v, input logic e3v, input logic advv,
                      input logic wenv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] bwn, input string req);
    bit sel, ech, rd, wr;
    logic [AW-1:0] oa;
    item_t it;
    @(negedge clk);
    e1_n = e1v; e2 = e2v; e3 = e3v; adv = advv; we_n = wenv; addr = a; din = d; bw_n = bwn;
    if (pend)
      for (int i = 0; i < NB; i++)
        if (!bwn[i]) mdl[pend_a][i*BW +: BW] = d[i*BW +: BW];
    ech = (e2v == e2_pol) && (e3v == e3_pol);
    sel = !e1v && ech;
    rd = 0; wr = 0; oa = '0;
    if (sel && !advv) begin
      rd = wenv; wr = !wenv; oa = a; loaded = 1; last_wr = !wenv; last_a = a;
    end else if (sel && advv && loaded) begin
      rd = !last_wr; wr = last_wr;
      oa = {last_a[AW-1:2], last_a[1:0] + 2'd1}; last_a = oa;
    end
    pend = wr; pend_a = oa;
    if (rd) begin en_m = 1'b1; dat_m = mdl[oa]; idle_prev = 0; end
    else if (wr) begin en_m = 1'b0; idle_prev = 0; end
    else begin if (idle_prev) en_m = 1'b0; idle_prev = 1; end
    it.due = cyc + 1; it.is_echo = 1; it.en = ech; it.dat = '0; it.req = "R9 echo";
    q.push_back(it);
    it.due = cyc + 2; it.is_echo = 0; it.en = en_m; it.dat = dat_m; it.req = req;
    q.push_back(it);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] bwn, input string req);
    step(1'b0, e2_pol, e3_pol, 1'b0, 1'b1, a, d, bwn, req);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] bwn, input string req);
    step(1'b0, e2_pol, e3_pol, 1'b0, 1'b0, a, d, bwn, req);
  endtask
  task automatic cont(input logic wenv, input logic [DW-1:0] d, input logic [NB-1:0] bwn, input string req);
    step(1'b0, e2_pol, e3_pol, 1'b1, wenv, '0, d, bwn, req);
  endtask
  task automatic idle(input logic [DW-1:0] d, input logic [NB-1:0] bwn, input string req);
    step(1'b1, e2_pol, e3_pol, 1'b0, 1'b1, '0, d, bwn, req);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  localparam logic [DW-1:0] GARB = 36'hFFF00FF00;
  localparam logic [DW-1:0] D1 = 36'h123456789;
  localparam logic [DW-1:0] D2 = 36'hABCDE0123;
  localparam logic [DW-1:0] D3 = 36'h0F1E2D3C4;
  localparam logic [DW-1:0] D4 = 36'h555AAA333;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 dout_en", DW'(dout_en), '0);
    check("R10 echo_en", DW'(echo_en), '0);
    check("R10 dout", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dout_en after release", DW'(dout_en), '0);

    // R7: continue before any load is idle
    cont(1'b1, '0, '1, "R7 read-continue ignored");
    cont(1'b0, '0, '1, "R7 write-continue ignored");
    idle(GARB, '0, "R7");
    idle('0, '1, "R7");

    // R3: late data; garbage on the command edge is ignored
    wr(6'd5, GARB, '0, "R3");
    idle(D1, '0, "R3");
    idle('0, '1, "R3");
    // R2 read then R8 dual-cycle deselect
    rd(6'd5, '0, '1, "R2 read of 5");
    idle('0, '1, "R8 first idle keeps output");
    idle('0, '1, "R8 second idle releases");
    idle('0, '1, "R8 stays released");

    // R5: read on the edge the write data lands
    wr(6'd8, GARB, '0, "R5");
    rd(6'd8, D2, '0, "R5 forwarded from buffer");
    wr(6'd9, '0, '1, "R8 write releases");
    wr(6'd8, D3, '0, "R5");
    rd(6'd8, D4, 4'b1010, "R4 partial merge");
    rd(6'd9, '0, '1, "R5 committed word");
    rd(6'd8, '0, '1, "R4 merged word again");
    idle('0, '1, "R8");
    idle('0, '1, "R8");

    // R6: burst write 14,15,12,13 then burst read across wrap
    wr(6'd14, '0, '1, "R6");
    cont(1'b0, D1, '0, "R6");
    cont(1'b0, D2, '0, "R6");
    cont(1'b0, D3, '0, "R6");
    idle(D4, '0, "R6");
    rd(6'd14, '0, '1, "R6 burst read 14");
    cont(1'b1, '0, '1, "R6 burst read 15");
    cont(1'b1, '0, '1, "R6 burst read 12 wrap");
    cont(1'b1, '0, '1, "R6 burst read 13");
    rd(6'd5, '0, '1, "R2 reload");

    // R9/R1: deselect via e2, e3, e1
    step(1'b0, ~e2_pol, e3_pol, 1'b0, 1'b1, 6'd9, '0, '1, "R1 e2 deselect");
    step(1'b0, e2_pol, ~e3_pol, 1'b0, 1'b0, 6'd9, '0, '1, "R1 e3 deselect no write");
    step(1'b1, e2_pol, e3_pol, 1'b0, 1'b1, 6'd9, GARB, '0, "R9 e1 deselect keeps echo");
    rd(6'd9, '0, '1, "R1 word 9 untouched");

    // R1: flipped strap polarity
    @(negedge clk);
    e2_pol = 1'b0; e3_pol = 1'b0;
    rd(6'd14, '0, '1, "R1 active-low straps select");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd5, '0, '1, "R1 e2 high now inactive");
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'd5, '0, '1, "R1 e3 high now inactive");
    rd(6'd12, '0, '1, "R1 active-low read");
    wr(6'd12, '0, '1, "R8 write after read releases");
    idle(D1, '0, "R4");
    rd(6'd12, '0, '1, "R4 full rewrite");

    repeat (6) idle('0, '1, "R8 drain");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule